// File: doc/BRIEF.md
# Bi-Endian Data Lane Steering Unit

This block sits between the load/store stage of a core and a 32-bit data bus. For each byte, halfword or word data access it works out the bus byte enables and moves the write data onto the right byte lanes. When the read data returns, it picks the value back out of the lanes and sign- or zero-extends it to 32 bits. Instruction fetch does not pass through this unit and stays little-endian.

The byte order of each access is chosen at run time. An address region table has the highest priority. Each of its four entries holds an enable, a base, a mask and an order bit. Below the table comes an override held in a local control register, and below that a strap pin. The core always sees natural values. Memory holds the bytes in the order that was selected for that access.

Top module: `endian_lane_steer`

## Requirements
- R1: After reset, no bus request and no response is produced, and the control-register override is cleared, so the strap pin decides the byte order.
- R2: The byte order of an access comes from the first matching region entry if there is one. Otherwise it comes from the override value when the override enable is set. Otherwise it comes from `strap_be_i`. The value 1 means big-endian.
- R3: Region k (k = 0..3) matches when `rgn_en_i[k]` is 1 and (addr & mask_k) == (base_k & mask_k). Base k and mask k sit at bits [32k+31:32k] of their buses. When several regions match, the lowest-numbered one wins.
- R4: On a clock edge with `ctl_wr_i` high, the override enable and the override value are loaded from `ctl_ovr_en_i` and `ctl_ovr_be_i`. At all other times they hold their value.
- R5: Byte lane k is bus bits [8k+7:8k]. Little-endian maps byte offset k (addr[1:0]) to lane k. Big-endian maps byte offset k to lane 3-k.
- R6: `req_size_i` is coded as 0 = byte, 1 = halfword, 2 = word. `bus_be_o` has a 1 for exactly the lanes that the access touches.
- R7: Write data puts the value's bytes in memory order. Little-endian puts the least significant byte at the lowest address. Big-endian puts the most significant byte at the lowest address. Lanes that are not enabled carry zero.
- R8: A read response rebuilds the value from the lanes using the byte order and offset that were captured at request time. It then sign-extends when `req_signed_i` was 1 and zero-extends otherwise. A word read is not changed by the signed flag.
- R9: The following accesses are misaligned or illegal: a halfword with addr[0] = 1, a word with addr[1:0] != 0, and size code 3. For these, `misalign_o` is 1, no bus request is issued, and no response follows. With no request present, `misalign_o` is 0.
- R10: `bus_addr_o` is the request address with its two low bits cleared, and `bus_we_o` follows the request direction.
- R11: `rsp_valid_o` pulses only with a `bus_rvalid_i` that answers an issued read. A write or a blocked access produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_be_i | input | 1 | Default byte order (1 = big-endian) |
| ctl_wr_i | input | 1 | Load the override register |
| ctl_ovr_en_i | input | 1 | Override enable value to load |
| ctl_ovr_be_i | input | 1 | Override byte order value to load |
| rgn_en_i | input | 4 | Region enables |
| rgn_base_i | input | 128 | Region bases, 32 bits each |
| rgn_mask_i | input | 128 | Region compare masks, 32 bits each |
| rgn_be_i | input | 4 | Region byte order bits |
| req_valid_i | input | 1 | Data access request |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size code |
| req_signed_i | input | 1 | Sign-extend load result |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store value, right-aligned |
| misalign_o | output | 1 | Misaligned or illegal access |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write |
| bus_addr_o | output | 32 | Word-aligned bus address |
| bus_be_o | output | 4 | Bus byte enables |
| bus_wdata_o | output | 32 | Lane-steered write data |
| bus_rvalid_i | input | 1 | Bus read data valid |
| bus_rdata_i | input | 32 | Bus read data |
| rsp_valid_o | output | 1 | Load result valid |
| rsp_rdata_o | output | 32 | Extended load result |

## Verification
The bench runs every access kind at every byte offset in both byte orders, checking each against a byte-array memory model. A design that mirrored the lanes the wrong way, or swapped bytes within a halfword, would put the enables or the data on the wrong lanes; a word access alone would not show it. Misaligned halfwords and words, and size code 3, must raise the flag with no request. A design that only checked addr[0] would let an offset-2 word through. The bench also tests the priority chain: two regions that overlap, a disabled region, a fourth region, and an override that must keep its value while its inputs change without a write strobe. A design that picked the highest-numbered region, or sampled the override inputs directly, would flip the enables of a byte access at offset 0. Sign extension is checked with set and clear top bits for each size. A word read with the signed flag set must come back unchanged.

// File: rtl/endian_steer_pkg.sv
package endian_steer_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/els_order_sel.sv
module els_order_sel #(
  parameter int AW   = 32,
  parameter int NREG = 4
) (
  input  logic [AW-1:0]      addr_i,
  input  logic               strap_be_i,
  input  logic               ovr_en_i,
  input  logic               ovr_be_i,
  input  logic [NREG-1:0]    rgn_en_i,
  input  logic [NREG*AW-1:0] rgn_base_i,
  input  logic [NREG*AW-1:0] rgn_mask_i,
  input  logic [NREG-1:0]    rgn_be_i,
  output logic               be_mode_o
);
  logic [NREG-1:0] hit;
  logic            any_hit;
  logic            rgn_order;

  for (genvar k = 0; k < NREG; k++) begin : g_rgn
    logic [AW-1:0] base_k, mask_k;
    assign base_k = rgn_base_i[k*AW +: AW];
    assign mask_k = rgn_mask_i[k*AW +: AW];
    assign hit[k] = rgn_en_i[k] && ((addr_i & mask_k) == (base_k & mask_k));
  end

  // descend so the lowest index is applied last and wins
  always_comb begin
    any_hit   = 1'b0;
    rgn_order = 1'b0;
    for (int k = NREG - 1; k >= 0; k--) begin
      if (hit[k]) begin
        any_hit   = 1'b1;
        rgn_order = rgn_be_i[k];
      end
    end
    if (any_hit)       be_mode_o = rgn_order;
    else if (ovr_en_i) be_mode_o = ovr_be_i;
    else               be_mode_o = strap_be_i;
  end
endmodule

// File: rtl/els_lane_pack.sv
module els_lane_pack #(
  parameter  int NB = 4,
  localparam int OW = $clog2(NB)
) (
  input  logic            be_mode_i,
  input  logic [1:0]      size_i,
  input  logic [OW-1:0]   off_i,
  input  logic [8*NB-1:0] val_i,
  output logic [NB-1:0]   be_o,
  output logic [8*NB-1:0] data_o
);
  int nb, m, lane, vb;

  always_comb begin
    be_o   = '0;
    data_o = '0;
    nb     = 1 << size_i;
    if (nb > NB) nb = NB;
    m = 0; lane = 0; vb = 0;
    for (int i = 0; i < NB; i++) begin
      m = int'(off_i) + i;
      if (i < nb && m < NB) begin
        lane = be_mode_i ? (NB - 1 - m) : m;
        vb   = be_mode_i ? (nb - 1 - i) : i;
        be_o[lane]           = 1'b1;
        data_o[lane*8 +: 8]  = val_i[vb*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/els_lane_unpack.sv
module els_lane_unpack #(
  parameter  int NB = 4,
  localparam int OW = $clog2(NB)
) (
  input  logic            be_mode_i,
  input  logic [1:0]      size_i,
  input  logic            signed_i,
  input  logic [OW-1:0]   off_i,
  input  logic [8*NB-1:0] lanes_i,
  output logic [8*NB-1:0] val_o
);
  int   nb, m, lane, vb;
  logic fill;

  always_comb begin
    val_o = '0;
    nb    = 1 << size_i;
    if (nb > NB) nb = NB;
    m = 0; lane = 0; vb = 0;
    for (int i = 0; i < NB; i++) begin
      m = int'(off_i) + i;
      if (i < nb && m < NB) begin
        lane = be_mode_i ? (NB - 1 - m) : m;
        vb   = be_mode_i ? (nb - 1 - i) : i;
        val_o[vb*8 +: 8] = lanes_i[lane*8 +: 8];
      end
    end
    fill = signed_i && val_o[8*nb - 1];
    for (int i = 0; i < NB; i++) begin
      if (i >= nb) val_o[i*8 +: 8] = {8{fill}};
    end
  end
endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import endian_steer_pkg::*;
#(
  parameter  int AW   = 32,
  parameter  int DW   = 32,
  parameter  int NREG = 4,
  localparam int NB   = DW / 8,
  localparam int OW   = $clog2(NB)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strap_be_i,
  input  logic               ctl_wr_i,
  input  logic               ctl_ovr_en_i,
  input  logic               ctl_ovr_be_i,
  input  logic [NREG-1:0]    rgn_en_i,
  input  logic [NREG*AW-1:0] rgn_base_i,
  input  logic [NREG*AW-1:0] rgn_mask_i,
  input  logic [NREG-1:0]    rgn_be_i,
  input  logic               req_valid_i,
  input  logic               req_we_i,
  input  logic [1:0]         req_size_i,
  input  logic               req_signed_i,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  output logic               misalign_o,
  output logic               bus_req_o,
  output logic               bus_we_o,
  output logic [AW-1:0]      bus_addr_o,
  output logic [NB-1:0]      bus_be_o,
  output logic [DW-1:0]      bus_wdata_o,
  input  logic               bus_rvalid_i,
  input  logic [DW-1:0]      bus_rdata_i,
  output logic               rsp_valid_o,
  output logic [DW-1:0]      rsp_rdata_o
);
  acc_size_e     size;
  logic [OW-1:0] off;
  logic          bad;
  logic          be_mode;

  logic          ovr_en_q, ovr_be_q;
  logic          pend_q, pend_be_q, pend_signed_q;
  logic [1:0]    pend_size_q;
  logic [OW-1:0] pend_off_q;

  assign size = acc_size_e'(req_size_i);
  assign off  = req_addr_i[OW-1:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = off[0];
      SZ_WORD: bad = |off;
      default: bad = 1'b1;
    endcase
  end

  assign misalign_o = req_valid_i && bad;
  assign bus_req_o  = req_valid_i && !bad;
  assign bus_we_o   = req_we_i;
  assign bus_addr_o = {req_addr_i[AW-1:OW], {OW{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_en_q <= 1'b0;
      ovr_be_q <= 1'b0;
    end else if (ctl_wr_i) begin
      ovr_en_q <= ctl_ovr_en_i;
      ovr_be_q <= ctl_ovr_be_i;
    end
  end

  els_order_sel #(.AW(AW), .NREG(NREG)) i_sel (
    .addr_i     (req_addr_i),
    .strap_be_i (strap_be_i),
    .ovr_en_i   (ovr_en_q),
    .ovr_be_i   (ovr_be_q),
    .rgn_en_i   (rgn_en_i),
    .rgn_base_i (rgn_base_i),
    .rgn_mask_i (rgn_mask_i),
    .rgn_be_i   (rgn_be_i),
    .be_mode_o  (be_mode)
  );

  els_lane_pack #(.NB(NB)) i_pack (
    .be_mode_i (be_mode),
    .size_i    (req_size_i),
    .off_i     (off),
    .val_i     (req_wdata_i),
    .be_o      (bus_be_o),
    .data_o    (bus_wdata_o)
  );

  // load context held until the bus answers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q        <= 1'b0;
      pend_be_q     <= 1'b0;
      pend_signed_q <= 1'b0;
      pend_size_q   <= 2'd0;
      pend_off_q    <= '0;
    end else if (bus_req_o && !req_we_i) begin
      pend_q        <= 1'b1;
      pend_be_q     <= be_mode;
      pend_signed_q <= req_signed_i;
      pend_size_q   <= req_size_i;
      pend_off_q    <= off;
    end else if (bus_rvalid_i) begin
      pend_q        <= 1'b0;
    end
  end

  assign rsp_valid_o = pend_q && bus_rvalid_i;

  els_lane_unpack #(.NB(NB)) i_unpack (
    .be_mode_i (pend_be_q),
    .size_i    (pend_size_q),
    .signed_i  (pend_signed_q),
    .off_i     (pend_off_q),
    .lanes_i   (bus_rdata_i),
    .val_o     (rsp_rdata_o)
  );
endmodule

// File: rtl/endian_lane_steer_chk.sv
module endian_lane_steer_chk #(
  parameter  int DW = 32,
  localparam int NB = DW / 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          misalign_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [NB-1:0] bus_be_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_rvalid_i,
  input logic          rsp_valid_o
);
  logic [DW-1:0] lane_mask;
  always_comb begin
    for (int k = 0; k < NB; k++) lane_mask[k*8 +: 8] = {8{bus_be_o[k]}};
  end

  // R9
  misalign_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !bus_req_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!bus_req_o && !misalign_o));

  // R6
  be_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> ($countones(bus_be_o) == 1 || $countones(bus_be_o) == 2 ||
                   $countones(bus_be_o) == 4));

  // R7
  unused_lane_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o) |-> ((bus_wdata_o & ~lane_mask) == '0));

  // R11
  rsp_needs_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> bus_rvalid_i);
endmodule

bind endian_lane_steer endian_lane_steer_chk #(.DW(DW)) i_endian_lane_steer_chk (.*);

// File: tb/test_endian_lane_steer.sv
module test_endian_lane_steer;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         strap_be_i = 1'b0;
  logic         ctl_wr_i = 1'b0, ctl_ovr_en_i = 1'b0, ctl_ovr_be_i = 1'b0;
  logic [3:0]   rgn_en_i = '0, rgn_be_i = '0;
  logic [127:0] rgn_base_i = '0, rgn_mask_i = '0;
  logic         req_valid_i = 1'b0, req_we_i = 1'b0, req_signed_i = 1'b0;
  logic [1:0]   req_size_i = '0;
  logic [31:0]  req_addr_i = '0, req_wdata_i = '0;
  logic         misalign_o, bus_req_o, bus_we_o, bus_rvalid_i = 1'b0, rsp_valid_o;
  logic [31:0]  bus_addr_o, bus_wdata_o, bus_rdata_i = '0, rsp_rdata_o;
  logic [3:0]   bus_be_o;

  int n_chk = 0, n_fail = 0;
  logic        s_mis, s_req, s_we, s_rv;
  logic [3:0]  s_be;
  logic [31:0] s_addr, s_wd, s_rd;

  always #4 clk_i = ~clk_i;

  endian_lane_steer i_endian_lane_steer (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc_write(input logic [1:0] sz, input logic [31:0] addr, input logic [31:0] v);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = 1'b1; req_size_i = sz; req_signed_i = 1'b0;
    req_addr_i = addr; req_wdata_i = v;
    #1;
    s_mis = misalign_o; s_req = bus_req_o; s_we = bus_we_o;
    s_be = bus_be_o; s_wd = bus_wdata_o; s_addr = bus_addr_o;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    bus_rvalid_i = 1'b1; bus_rdata_i = 32'hDEAD_BEEF;
    #1; s_rv = rsp_valid_o;
    @(negedge clk_i);
    bus_rvalid_i = 1'b0;
  endtask

  task automatic acc_read(input logic [1:0] sz, input logic sg, input logic [31:0] addr,
                          input logic [31:0] rd);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = 1'b0; req_size_i = sz; req_signed_i = sg;
    req_addr_i = addr; req_wdata_i = 32'h0;
    #1;
    s_mis = misalign_o; s_req = bus_req_o; s_we = bus_we_o; s_addr = bus_addr_o;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    bus_rvalid_i = 1'b1; bus_rdata_i = rd;
    #1; s_rv = rsp_valid_o; s_rd = rsp_rdata_o;
    @(negedge clk_i);
    bus_rvalid_i = 1'b0;
  endtask

  task automatic set_ctl(input logic en, input logic be);
    @(negedge clk_i);
    ctl_wr_i = 1'b1; ctl_ovr_en_i = en; ctl_ovr_be_i = be;
    @(negedge clk_i);
    ctl_wr_i = 1'b0;
  endtask

  // byte-array reference: memory byte at word offset a lives on lane (big ? 3-a : a)
  function automatic void model_wr(input bit big, input int sz, input int off,
                                   input logic [31:0] v, output logic [3:0] eb,
                                   output logic [31:0] ew);
    logic [7:0] mem [4];
    bit         used [4];
    int n = 1 << sz;
    for (int a = 0; a < 4; a++) begin mem[a] = 8'h0; used[a] = 1'b0; end
    for (int i = 0; i < n; i++) begin
      mem[off+i]  = big ? v[8*(n-1-i) +: 8] : v[8*i +: 8];
      used[off+i] = 1'b1;
    end
    eb = '0; ew = '0;
    for (int a = 0; a < 4; a++) begin
      if (used[a]) begin
        eb[big ? 3-a : a]              = 1'b1;
        ew[8*(big ? 3-a : a) +: 8]     = mem[a];
      end
    end
  endfunction

  function automatic logic [31:0] model_rd(input bit big, input int sz, input bit sg,
                                           input int off, input logic [31:0] rd);
    logic [7:0]  mem [4];
    logic [31:0] v = '0;
    int n = 1 << sz;
    for (int a = 0; a < 4; a++) mem[a] = rd[8*(big ? 3-a : a) +: 8];
    for (int i = 0; i < n; i++) begin
      if (big) v = (v << 8) | {24'h0, mem[off+i]};
      else     v = v | ({24'h0, mem[off+i]} << (8*i));
    end
    if (sg && n < 4 && v[8*n-1]) v = v | ~((32'h1 << (8*n)) - 32'h1);
    return v;
  endfunction

  // {size, signed}
  localparam logic [2:0] KINDS [5] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100};
  localparam logic [31:0] PATS [4] = '{32'h8123_45F6, 32'h7F00_A5C3,
                                       32'hFFFF_FFFF, 32'h0102_0384};

  initial begin : watchdog
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [3:0]  eb;
    logic [31:0] ew, rd;
    // R1 during reset: no response even with bus valid
    #20;
    bus_rvalid_i = 1'b1;
    #1;
    chk("R1 no bus_req in reset", {31'h0, bus_req_o}, 32'h0);
    chk("R1 no rsp in reset", {31'h0, rsp_valid_o}, 32'h0);
    bus_rvalid_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 override clear after reset, strap decides
    strap_be_i = 1'b0;
    acc_write(2'd0, 32'h1000, 32'hAB);
    chk("R1 strap LE byte be", {28'h0, s_be}, 32'h1);
    strap_be_i = 1'b1;
    acc_write(2'd0, 32'h1000, 32'hAB);
    chk("R2 strap BE byte be", {28'h0, s_be}, 32'h8);

    // sweep: kinds x offsets x order x patterns (R5 R6 R7 R8 R9 R10 R11)
    for (int idx = 0; idx < 160; idx++) begin
      int  kd  = idx % 5;
      int  off = (idx / 5) % 4;
      bit  big = ((idx / 20) % 2) == 1;
      int  pt  = idx / 40;
      int  sz  = int'(KINDS[kd][2:1]);
      bit  sg  = KINDS[kd][0];
      bit  ok  = (off % (1 << sz)) == 0;
      strap_be_i = big;
      acc_write(KINDS[kd][2:1], 32'h1000 + off, PATS[pt]);
      if (ok) begin
        model_wr(big, sz, off, PATS[pt], eb, ew);
        chk("R6 write be", {28'h0, s_be}, {28'h0, eb});
        chk("R7 write data lanes", s_wd, ew);
        chk("R10 write addr/we", {s_addr[31:1], s_we}, {31'h800, 1'b1});
        chk("R11 no rsp after write", {31'h0, s_rv}, 32'h0);
      end else begin
        chk("R9 misaligned write flag/req", {30'h0, s_mis, s_req}, 32'h2);
      end
      rd = PATS[(pt + 1) % 4] ^ 32'h5A5A_A5A5;
      acc_read(KINDS[kd][2:1], sg, 32'h1000 + off, rd);
      if (ok) begin
        chk("R10 read req/we", {30'h0, s_req, s_we}, 32'h2);
        chk("R8 read value", s_rd, model_rd(big, sz, sg, off, rd));
        chk("R11 read rsp valid", {31'h0, s_rv}, 32'h1);
      end else begin
        chk("R9 misaligned read flag/req", {30'h0, s_mis, s_req}, 32'h2);
        chk("R9 no rsp after blocked read", {31'h0, s_rv}, 32'h0);
      end
    end

    // R8 signed word unchanged, both orders
    strap_be_i = 1'b0;
    acc_read(2'd2, 1'b1, 32'h1000, 32'h8000_0001);
    chk("R8 signed word LE", s_rd, 32'h8000_0001);
    strap_be_i = 1'b1;
    acc_read(2'd2, 1'b1, 32'h1000, 32'h8000_0001);
    chk("R8 signed word BE", s_rd, 32'h8000_0001);

    // R9 reserved size code 3
    acc_write(2'd3, 32'h1000, 32'h1);
    chk("R9 size code 3 flagged", {30'h0, s_mis, s_req}, 32'h2);

    // R2/R4 override over strap, and hold without write strobe
    strap_be_i = 1'b0;
    set_ctl(1'b1, 1'b1);
    acc_write(2'd0, 32'h1000, 32'h5);
    chk("R2 override BE beats strap LE", {28'h0, s_be}, 32'h8);
    strap_be_i = 1'b1;
    set_ctl(1'b1, 1'b0);
    acc_write(2'd0, 32'h1000, 32'h5);
    chk("R2 override LE beats strap BE", {28'h0, s_be}, 32'h1);
    @(negedge clk_i); ctl_ovr_be_i = 1'b1; ctl_ovr_en_i = 1'b0;
    @(negedge clk_i);
    acc_write(2'd0, 32'h1000, 32'h5);
    chk("R4 override holds without strobe", {28'h0, s_be}, 32'h1);
    set_ctl(1'b0, 1'b0);
    acc_write(2'd0, 32'h1000, 32'h5);
    chk("R4 override disabled -> strap BE", {28'h0, s_be}, 32'h8);

    // R3 regions over override BE
    strap_be_i = 1'b0;
    set_ctl(1'b1, 1'b1);
    rgn_base_i[31:0]  = 32'h0000_2000; rgn_mask_i[31:0]  = 32'hFFFF_F000;
    rgn_base_i[63:32] = 32'h0000_2000; rgn_mask_i[63:32] = 32'hFFFF_0000;
    rgn_be_i = 4'b0010; rgn_en_i = 4'b0011;
    acc_write(2'd0, 32'h2004, 32'h5);
    chk("R3 lowest region wins (LE)", {28'h0, s_be}, 32'h1);
    acc_write(2'd1, 32'h2006, 32'h1234);
    chk("R3 region LE half data", s_wd, 32'h1234_0000);
    acc_write(2'd0, 32'h3004, 32'h5);
    chk("R3 region1 only (BE)", {28'h0, s_be}, 32'h8);
    acc_write(2'd0, 32'h1_3004, 32'h5);
    chk("R2 no region -> override BE", {28'h0, s_be}, 32'h8);
    rgn_base_i[127:96] = 32'h0001_3000; rgn_mask_i[127:96] = 32'hFFFF_F000;
    rgn_en_i[3] = 1'b1; rgn_be_i[3] = 1'b0;
    acc_write(2'd0, 32'h1_3004, 32'h5);
    chk("R3 region3 LE beats override", {28'h0, s_be}, 32'h1);
    rgn_en_i[0] = 1'b0;
    acc_write(2'd0, 32'h2004, 32'h5);
    chk("R3 disabled region skipped", {28'h0, s_be}, 32'h8);
    acc_read(2'd1, 1'b1, 32'h2004, 32'h80FF_0000);
    chk("R8 region BE signed half", s_rd, 32'hFFFF_80FF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule